// File: doc/BRIEF.md
# Infrared Receive FIFO and Interrupt Register Block

This block sits between an infrared run-length sampler and a simple synchronous register bus. The sampler hands over one byte per push together with a packet-end pulse. The block stores the bytes in a byte-wide FIFO. The processor drains that FIFO through a data register. Configuration registers hold the enables, the mode and the sampler thresholds, and these values are driven straight back to the sampler.

A sticky status register records three events: FIFO overflow, packet end, and FIFO fill above a programmable level. Software clears these flags by writing ones to them. The status register also reports the live fill count. A single level-sensitive interrupt line is raised while any pending flag has its enable bit set.

Bus accesses take one cycle. `busSel` qualifies an access and `busWr` selects a write. Read data is registered and appears on `busRdata` after the clock edge that samples the read.

Top module: `ir_rx_fifo_regs`

## Requirements
- R1: After reset every register, the fill count, `busRdata` and `irq` are zero.
- R2: The control register at 0x00 holds global enable in bit 0, receive enable in bit 1 and mode in bits 5:4, and reads back with all other bits zero. Sampler pushes and packet-end pulses are ignored unless both bit 0 and bit 1 are set.
- R3: Bytes leave the FIFO in the order they were pushed. A read of 0x20 returns the oldest byte in bits 7:0 and removes it. A read of 0x20 while the FIFO is empty returns zero and leaves the count unchanged.
- R4: The status register at 0x30 reports the fill count (0 to DEPTH) in bits starting at bit 8.
- R5: A push into a full FIFO with no pop in the same cycle is discarded, and it sets the overflow flag (status bit 0).
- R6: A packet-end pulse sets status bit 1.
- R7: Status bit 4 (data available) is set in the cycle after the fill count exceeds the level field. The level field sits at bits [8 +: log2(DEPTH)] of the interrupt-enable register at 0x2C.
- R8: Writing a one to status bit 0, 1 or 4 clears that flag. If a set event falls in the same cycle as the clear, the set event wins.
- R9: `irq` is high exactly when some status flag at bit 0, 1 or 4 is set and the bit at the same position in 0x2C is also set.
- R10: Bit 2 of the receive-control register at 0x10 is the polarity invert. The sample-configuration register at 0x34 holds the noise threshold in bits 7:2 and the idle threshold in bits 15:8. All of these read back and are driven to the sampler outputs.
- R11: When a push and a pop happen in the same cycle on a full FIFO, both take effect. The fill count stays at DEPTH and no overflow is flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Bus access strobe |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 8 | Register byte offset |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Registered read data |
| smpPushValid | input | 1 | Sampler byte valid |
| smpPushData | input | 8 | Sampler byte |
| smpPktEnd | input | 1 | Sampler packet-end pulse |
| cfgGlobalEn | output | 1 | Global enable to sampler |
| cfgRxEn | output | 1 | Receive enable to sampler |
| cfgMode | output | 2 | Mode field to sampler |
| cfgInvert | output | 1 | Input polarity invert |
| cfgNoise | output | 6 | Noise threshold |
| cfgIdle | output | 8 | Idle threshold |
| irq | output | 1 | Level interrupt |

## Verification
Two cases are driven in the same cycle. In the first, a status write that clears the overflow flag arrives in the same cycle as a push into a full FIFO. The bench reads the status back afterwards and expects the overflow bit still set, because the set event wins. In the second, a FIFO data read arrives in the same cycle as a sampler push while the FIFO is full. The bench expects the oldest byte on the bus, a fill count that stays at DEPTH and no overflow flag. It then drains the FIFO and checks that the newly pushed byte comes out last.

// File: rtl/ir_rx_pkg.sv
package ir_rx_pkg;
  localparam logic [7:0] ADDR_CTRL   = 8'h00;
  localparam logic [7:0] ADDR_RXCTL  = 8'h10;
  localparam logic [7:0] ADDR_FIFO   = 8'h20;
  localparam logic [7:0] ADDR_INTEN  = 8'h2C;
  localparam logic [7:0] ADDR_STATUS = 8'h30;
  localparam logic [7:0] ADDR_SMPCFG = 8'h34;

  localparam int BIT_OVF   = 0;
  localparam int BIT_PKT   = 1;
  localparam int BIT_AVAIL = 4;

  typedef struct packed {
    logic push;
    logic pop;
  } fifoStrb_t;
endpackage

// File: rtl/ir_rx_fifo_dp.sv
module ir_rx_fifo_dp
  import ir_rx_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DW    = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  fifoStrb_t                  strb,
  input  logic [DW-1:0]              wrData,
  output logic [DW-1:0]              headData,
  output logic [$clog2(DEPTH):0]     fillCount,
  output logic                       full,
  output logic                       empty
);
  localparam int AW    = $clog2(DEPTH);
  localparam int CNT_W = AW + 1;

  logic [DW-1:0]    mem [DEPTH];
  logic [AW-1:0]    wrPtr, rdPtr;
  logic [CNT_W-1:0] count;
  logic             doPush, doPop;

  assign full      = (count == CNT_W'(DEPTH));
  assign empty     = (count == '0);
  assign doPop     = strb.pop & ~empty;
  assign doPush    = strb.push & (~full | doPop);
  assign headData  = mem[rdPtr];
  assign fillCount = count;

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= wrPtr + 1'b1;
      if (doPop)  rdPtr <= rdPtr + 1'b1;
      count <= count + CNT_W'(doPush) - CNT_W'(doPop);
    end
  end

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(DEPTH)); // R4
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    (full && !strb.pop) |=> (count == CNT_W'(DEPTH))); // R5
  AST_POP_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    (empty && !strb.push) |=> empty); // R3
endmodule

// File: rtl/ir_rx_fifo_ctl.sv
module ir_rx_fifo_ctl
  import ir_rx_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   busSel,
  input  logic                   busWr,
  input  logic [7:0]             busAddr,
  input  logic [31:0]            busWdata,
  output logic [31:0]            busRdata,
  input  logic                   smpPushValid,
  input  logic                   smpPktEnd,
  input  logic [7:0]             headData,
  input  logic [$clog2(DEPTH):0] fillCount,
  input  logic                   full,
  input  logic                   empty,
  output fifoStrb_t              strb,
  output logic                   cfgGlobalEn,
  output logic                   cfgRxEn,
  output logic [1:0]             cfgMode,
  output logic                   cfgInvert,
  output logic [5:0]             cfgNoise,
  output logic [7:0]             cfgIdle,
  output logic                   irq
);
  localparam int AW    = $clog2(DEPTH);
  localparam int CNT_W = AW + 1;

  logic          ovfEn, pktEn, availEn;
  logic [AW-1:0] level;
  logic          ovfFlag, pktFlag, availFlag;
  logic          wrStb, rdStb, rxOn;
  logic          ovfEvt, pktEvt, availEvt;
  logic          ovfClr, pktClr, availClr;
  logic [31:0]   rdVal;

  assign wrStb = busSel & busWr;
  assign rdStb = busSel & ~busWr;
  assign rxOn  = cfgGlobalEn & cfgRxEn;

  assign strb.pop  = rdStb & (busAddr == ADDR_FIFO) & ~empty;
  assign strb.push = rxOn & smpPushValid & (~full | strb.pop);

  assign ovfEvt   = rxOn & smpPushValid & full & ~strb.pop;
  assign pktEvt   = rxOn & smpPktEnd;
  assign availEvt = fillCount > {1'b0, level};

  assign ovfClr   = wrStb & (busAddr == ADDR_STATUS) & busWdata[BIT_OVF];
  assign pktClr   = wrStb & (busAddr == ADDR_STATUS) & busWdata[BIT_PKT];
  assign availClr = wrStb & (busAddr == ADDR_STATUS) & busWdata[BIT_AVAIL];

  assign irq = (ovfFlag & ovfEn) | (pktFlag & pktEn) | (availFlag & availEn);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgGlobalEn <= 1'b0;
      cfgRxEn     <= 1'b0;
      cfgMode     <= '0;
      cfgInvert   <= 1'b0;
      cfgNoise    <= '0;
      cfgIdle     <= '0;
      ovfEn       <= 1'b0;
      pktEn       <= 1'b0;
      availEn     <= 1'b0;
      level       <= '0;
    end else if (wrStb) begin
      case (busAddr)
        ADDR_CTRL: begin
          cfgGlobalEn <= busWdata[0];
          cfgRxEn     <= busWdata[1];
          cfgMode     <= busWdata[5:4];
        end
        ADDR_RXCTL: cfgInvert <= busWdata[2];
        ADDR_INTEN: begin
          ovfEn   <= busWdata[BIT_OVF];
          pktEn   <= busWdata[BIT_PKT];
          availEn <= busWdata[BIT_AVAIL];
          level   <= busWdata[8 +: AW];
        end
        ADDR_SMPCFG: begin
          cfgNoise <= busWdata[7:2];
          cfgIdle  <= busWdata[15:8];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ovfFlag   <= 1'b0;
      pktFlag   <= 1'b0;
      availFlag <= 1'b0;
    end else begin
      ovfFlag   <= ovfEvt   | (ovfFlag   & ~ovfClr);
      pktFlag   <= pktEvt   | (pktFlag   & ~pktClr);
      availFlag <= availEvt | (availFlag & ~availClr);
    end
  end

  always_comb begin
    rdVal = '0;
    case (busAddr)
      ADDR_CTRL:   rdVal = {26'b0, cfgMode, 2'b00, cfgRxEn, cfgGlobalEn};
      ADDR_RXCTL:  rdVal = {29'b0, cfgInvert, 2'b00};
      ADDR_FIFO:   rdVal = {24'b0, (empty ? 8'h00 : headData)};
      ADDR_INTEN: begin
        rdVal[BIT_OVF]   = ovfEn;
        rdVal[BIT_PKT]   = pktEn;
        rdVal[BIT_AVAIL] = availEn;
        rdVal[8 +: AW]   = level;
      end
      ADDR_STATUS: begin
        rdVal[BIT_OVF]    = ovfFlag;
        rdVal[BIT_PKT]    = pktFlag;
        rdVal[BIT_AVAIL]  = availFlag;
        rdVal[8 +: CNT_W] = fillCount;
      end
      ADDR_SMPCFG: rdVal = {16'b0, cfgIdle, cfgNoise, 2'b00};
      default:     rdVal = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) busRdata <= '0;
    else       busRdata <= rdStb ? rdVal : '0;
  end

  AST_OVF_SET: assert property (@(posedge clk) disable iff (!rstN)
    (rxOn && smpPushValid && full && !strb.pop) |=> ovfFlag); // R5
  AST_PKT_SET: assert property (@(posedge clk) disable iff (!rstN)
    (cfgGlobalEn && cfgRxEn && smpPktEnd) |=> pktFlag); // R6
  AST_W1C_OVF: assert property (@(posedge clk) disable iff (!rstN)
    (ovfClr && !(rxOn && smpPushValid && full && !strb.pop)) |=> !ovfFlag); // R8
  AST_RX_GATED: assert property (@(posedge clk) disable iff (!rstN)
    (!(cfgGlobalEn && cfgRxEn) && !strb.pop) |=> $stable(fillCount)); // R2
endmodule

// File: rtl/ir_rx_fifo_regs.sv
module ir_rx_fifo_regs
  import ir_rx_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        busSel,
  input  logic        busWr,
  input  logic [7:0]  busAddr,
  input  logic [31:0] busWdata,
  output logic [31:0] busRdata,
  input  logic        smpPushValid,
  input  logic [7:0]  smpPushData,
  input  logic        smpPktEnd,
  output logic        cfgGlobalEn,
  output logic        cfgRxEn,
  output logic [1:0]  cfgMode,
  output logic        cfgInvert,
  output logic [5:0]  cfgNoise,
  output logic [7:0]  cfgIdle,
  output logic        irq
);
  localparam int CNT_W = $clog2(DEPTH) + 1;

  fifoStrb_t        strb;
  logic [7:0]       headData;
  logic [CNT_W-1:0] fillCount;
  logic             full, empty;

  ir_rx_fifo_ctl #(.DEPTH(DEPTH)) u_ctl (
    .clk, .rstN, .busSel, .busWr, .busAddr, .busWdata, .busRdata,
    .smpPushValid, .smpPktEnd, .headData, .fillCount, .full, .empty,
    .strb, .cfgGlobalEn, .cfgRxEn, .cfgMode, .cfgInvert, .cfgNoise,
    .cfgIdle, .irq
  );

  ir_rx_fifo_dp #(.DEPTH(DEPTH), .DW(8)) u_dp (
    .clk, .rstN, .strb, .wrData(smpPushData), .headData, .fillCount,
    .full, .empty
  );
endmodule

// File: tb/ir_rx_fifo_regs_bench.sv
`timescale 1ns/1ps
module ir_rx_fifo_regs_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0, busWr = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        smpPushValid = 1'b0, smpPktEnd = 1'b0;
  logic [7:0]  smpPushData = '0;
  logic        cfgGlobalEn, cfgRxEn, cfgInvert, irq;
  logic [1:0]  cfgMode;
  logic [5:0]  cfgNoise;
  logic [7:0]  cfgIdle;
  int checks = 0, errors = 0;
  logic [31:0] rd;

  always #5 clk = ~clk;

  ir_rx_fifo_regs #(.DEPTH(16)) u_ir_rx_fifo_regs (
    .clk, .rstN, .busSel, .busWr, .busAddr, .busWdata, .busRdata,
    .smpPushValid, .smpPushData, .smpPktEnd, .cfgGlobalEn, .cfgRxEn,
    .cfgMode, .cfgInvert, .cfgNoise, .cfgIdle, .irq
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic busOp(input bit sel, input bit wr, input logic [7:0] addr,
                       input logic [31:0] wdata, input bit push,
                       input logic [7:0] pdata, input bit pkt,
                       output logic [31:0] rdOut);
    @(negedge clk);
    busSel = sel; busWr = wr; busAddr = addr; busWdata = wdata;
    smpPushValid = push; smpPushData = pdata; smpPktEnd = pkt;
    @(negedge clk);
    rdOut = busRdata;
    busSel = 0; busWr = 0; smpPushValid = 0; smpPktEnd = 0;
  endtask

  task automatic wrReg(input logic [7:0] a, input logic [31:0] d);
    logic [31:0] x;
    busOp(1, 1, a, d, 0, 0, 0, x);
  endtask

  task automatic rdReg(input logic [7:0] a, output logic [31:0] d);
    busOp(1, 0, a, 0, 0, 0, 0, d);
  endtask

  task automatic push(input logic [7:0] b);
    logic [31:0] x;
    busOp(0, 0, 0, 0, 1, b, 0, x);
  endtask

  task automatic testReset();
    chk("R1 rdata", busRdata, 0);
    chk("R1 irq", irq, 0);
    rdReg(8'h00, rd); chk("R1 ctrl", rd, 0);
    rdReg(8'h30, rd); chk("R1 status", rd, 0);
    rdReg(8'h34, rd); chk("R1 smpcfg", rd, 0);
  endtask

  task automatic testConfig();
    wrReg(8'h00, 32'hFFFF_FF33);
    rdReg(8'h00, rd); chk("R2 ctrl readback", rd, 32'h33);
    chk("R2 ctrl outs", {cfgMode, cfgRxEn, cfgGlobalEn}, 4'hF);
    wrReg(8'h10, 32'h0000_0004);
    rdReg(8'h10, rd); chk("R10 rxctl readback", rd, 32'h4);
    wrReg(8'h34, 32'hFFFF_AB15);
    rdReg(8'h34, rd); chk("R10 smpcfg readback", rd, 32'hAB14);
    chk("R10 cfg outs", {cfgInvert, cfgNoise, cfgIdle}, {1'b1, 6'd5, 8'hAB});
  endtask

  task automatic testOrder();
    push(8'h11); push(8'h22); push(8'h33);
    rdReg(8'h30, rd); chk("R4 count 3", rd, 32'h0310);
    rdReg(8'h20, rd); chk("R3 first", rd, 32'h11);
    rdReg(8'h20, rd); chk("R3 second", rd, 32'h22);
    rdReg(8'h20, rd); chk("R3 third", rd, 32'h33);
    rdReg(8'h20, rd); chk("R3 empty read", rd, 0);
    wrReg(8'h30, 32'h13);
    rdReg(8'h30, rd); chk("R3 count 0 after empty read", rd, 0);
  endtask

  task automatic testAvail();
    wrReg(8'h2C, 32'h0000_0210);
    push(8'hA1); push(8'hA2);
    rdReg(8'h30, rd); chk("R7 at level not set", rd, 32'h0200);
    chk("R9 irq low", irq, 0);
    push(8'hA3);
    rdReg(8'h30, rd); chk("R7 above level", rd, 32'h0310);
    chk("R9 irq avail", irq, 1);
    rdReg(8'h20, rd); chk("R3 pop A1", rd, 32'hA1);
    wrReg(8'h30, 32'h10);
    rdReg(8'h30, rd); chk("R8 avail cleared", rd, 32'h0200);
    chk("R9 irq cleared", irq, 0);
  endtask

  task automatic testOverflow();
    wrReg(8'h2C, 32'h1);
    for (int i = 0; i < 14; i++) push(8'h10 + 8'(i));
    rdReg(8'h30, rd); chk("R4 full count", rd, 32'h1010);
    chk("R9 irq masked", irq, 0);
    push(8'hEE);
    rdReg(8'h30, rd); chk("R5 overflow flag", rd, 32'h1011);
    chk("R9 irq ovf", irq, 1);
    wrReg(8'h30, 32'h11);
    rdReg(8'h30, rd); chk("R8 ovf cleared, avail re-set", rd, 32'h1010);
    chk("R9 irq after clear", irq, 0);
    busOp(1, 1, 8'h30, 32'h1, 1, 8'hEF, 0, rd);
    rdReg(8'h30, rd); chk("R8 set beats clear", rd, 32'h1011);
    wrReg(8'h30, 32'h1);
  endtask

  task automatic testPushPopFull();
    busOp(1, 0, 8'h20, 0, 1, 8'hBB, 0, rd);
    chk("R11 pop data", rd, 32'hA2);
    rdReg(8'h30, rd); chk("R11 count held no ovf", rd, 32'h1010);
    rdReg(8'h20, rd); chk("R3 drain A3", rd, 32'hA3);
    for (int i = 0; i < 14; i++) begin
      rdReg(8'h20, rd); chk("R3 drain", rd, 32'h10 + i);
    end
    rdReg(8'h20, rd); chk("R11 late byte last", rd, 32'hBB);
    wrReg(8'h30, 32'h10);
    rdReg(8'h30, rd); chk("R4 empty", rd, 0);
  endtask

  task automatic testPacket();
    busOp(0, 0, 0, 0, 0, 0, 1, rd);
    rdReg(8'h30, rd); chk("R6 pkt flag", rd, 32'h2);
    chk("R9 irq masked pkt", irq, 0);
    wrReg(8'h2C, 32'h2);
    chk("R9 irq pkt", irq, 1);
    wrReg(8'h30, 32'h2);
    chk("R8 pkt cleared irq", irq, 0);
    wrReg(8'h00, 32'h31);
    busOp(0, 0, 0, 0, 1, 8'h55, 1, rd);
    rdReg(8'h30, rd); chk("R2 rx disabled ignores", rd, 0);
    chk("R2 irq stays low", irq, 0);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testConfig();
    testOrder();
    testAvail();
    testOverflow();
    testPushPopFull();
    testPacket();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule